// File: doc/BRIEF.md
# AUX Request Header Framer

This block turns one auxiliary-channel request into the byte sequence that goes out on the wire. A request arrives as a single-cycle start strobe. With it come a 4-bit command, a 20-bit target address, a payload length, a direction flag, a flat vector of payload bytes and a start delay. The block accepts a start only while it is idle. It then writes the frame into a small transmit buffer, one byte per cycle. The first write puts the buffer pointer at slot 0 without advancing it. Every later write lands at the pointer and then advances it.

Once the buffer holds the frame, the block sends a one-cycle acknowledge to clear the sender's completion flag. It waits until that flag reads low, then raises a one-cycle go strobe. After the programmed delay, it presents the buffered bytes in order on a valid/ready byte port. The number of bytes to send is exposed as a count. A request longer than the buffer can hold is refused with an error pulse and never reaches the line. Line coding and the electrical layer sit elsewhere.

Top module: `aux_req_framer`

## Requirements
- R1: The first byte sent carries the command in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: The second byte sent is address bits 15:8 and the third is address bits 7:0.
- R3: For a nonzero length the fourth byte is the length minus one, for reads and writes alike; for a zero length no such byte exists.
- R4: `tx_count`, valid from go onward, equals 3 for a zero length or 4 otherwise, plus the length when `req_write` is 1; exactly that many bytes are sent.
- R5: For writes, payload byte i (taken from `req_data[8*i+7:8*i]`) follows the length byte in ascending order of i; reads send no payload.
- R6: `done_ack` pulses for one cycle once the buffer is loaded, and `go` pulses for one cycle only after that and only while `tx_done` is low; while `tx_done` stays high, `go` is withheld.
- R7: With start delay D, the first byte becomes valid on the (D+1)-th clock edge after the cycle in which `go` is high.
- R8: While `byte_valid` is high and `byte_ready` is low, `byte_valid` and `byte_data` hold; after the last byte is accepted, `byte_valid` is low.
- R9: `busy` is high from the `go` cycle until the clock edge that accepts the last byte, and low after it.
- R10: A start with `req_len` above MAX_LEN (16 by default) produces a one-cycle `req_err` pulse in the next cycle, and no `done_ack` or `go`.
- R11: A start that arrives while a request is being loaded, waited on or sent is ignored: the current frame is unchanged and nothing is queued.
- R12: During and after reset, `busy`, `go`, `done_ack`, `req_err` and `byte_valid` are low and `tx_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request strobe, honoured only when idle |
| req_cmd | input | 4 | Request command code |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W (5) | Payload length in bytes |
| req_write | input | 1 | 1 = write (payload sent), 0 = read |
| req_data | input | 8*MAX_LEN (128) | Payload bytes, byte i at bits 8*i+7:8*i |
| req_delay | input | DLY_W (4) | Cycles between go and the first byte |
| req_err | output | 1 | One-cycle pulse: request length too large |
| done_ack | output | 1 | One-cycle acknowledge of the sender's completion flag |
| tx_done | input | 1 | Sender's completion flag |
| go | output | 1 | One-cycle transmit start strobe |
| tx_count | output | CNT_W (5) | Number of bytes in the frame |
| busy | output | 1 | Frame transmission in progress |
| byte_valid | output | 1 | Byte output valid |
| byte_ready | input | 1 | Byte output ready |
| byte_data | output | 8 | Byte output data |

## Verification
Requests are drawn from a table that covers every combination of zero and nonzero length with read and write. The zero-length write shows that the direction flag alone adds no bytes. The nonzero reads show that the length byte appears even though no payload follows. Lengths 1, 4 and 16 exercise payload ordering up to the full buffer. Each request uses one of three ready patterns: always ready, alternating, and stalled at the start. These separate correct stall holding from a pointer that advances on valid alone. Delays of 0 to 15 and varying hold times on the completion flag test go timing. Directed cases cover oversize lengths, a start injected mid-stream that must be dropped, and the reset state.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ACK,
    ST_WAIT,
    ST_GO,
    ST_SEND
  } frm_state_e;

  // Header byte selected by position 0..2 within the frame.
  function automatic logic [7:0] hdr_byte(input logic [3:0]  cmd,
                                          input logic [19:0] addr,
                                          input logic [1:0]  pos);
    logic [7:0] b;
    case (pos)
      2'd0:    b = {cmd, addr[19:16]};
      2'd1:    b = addr[15:8];
      default: b = addr[7:0];
    endcase
    return b;
  endfunction

  // Number of bytes in a frame: header, optional length byte, write payload.
  function automatic int unsigned frame_len(input int unsigned len,
                                            input logic        is_wr);
    int unsigned n;
    n = (len != 0) ? 4 : 3;
    if (is_wr) n = n + len;
    return n;
  endfunction

endpackage

// File: rtl/aux_frm_buf.sv
module aux_frm_buf #(
  parameter int DEPTH = 20,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_first,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] wptr;
  logic [IDX_W-1:0] wr_at;

  // First write goes to slot 0 with no increment; later writes auto-increment.
  assign wr_at = wr_first ? '0 : wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (wr_en) begin
      if (wr_first) wptr <= IDX_W'(1);
      else          wptr <= wptr + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_at] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/aux_frm_seq.sv
module aux_frm_seq
  import aux_frm_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5,
  parameter int CNT_W   = 5,
  parameter int DLY_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_start,
  input  logic [3:0]           req_cmd,
  input  logic [19:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 req_write,
  input  logic [8*MAX_LEN-1:0] req_data,
  input  logic [DLY_W-1:0]     req_delay,
  input  logic                 tx_done,
  input  logic                 last_acc,
  output logic                 req_err,
  output logic                 done_ack,
  output logic                 go,
  output logic [CNT_W-1:0]     tx_count,
  output logic [DLY_W-1:0]     dly_q,
  output logic                 wr_en,
  output logic                 wr_first,
  output logic [7:0]           wr_data
);

  localparam int PW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  frm_state_e           state;
  logic [CNT_W-1:0]     k;
  logic [3:0]           cmd_q;
  logic [19:0]          addr_q;
  logic [LEN_W-1:0]     len_q;
  logic                 wr_q;
  logic [8*MAX_LEN-1:0] data_q;
  logic [7:0]           pay_b [MAX_LEN];
  logic [PW-1:0]        pidx;
  logic                 too_big;
  logic                 load_last;

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_pay
    assign pay_b[i] = data_q[8*i +: 8];
  end

  assign too_big   = req_len > LEN_W'(MAX_LEN);
  assign load_last = (k == tx_count - CNT_W'(1));
  assign pidx      = (k >= CNT_W'(4)) ? PW'(k - CNT_W'(4)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      k        <= '0;
      cmd_q    <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      wr_q     <= 1'b0;
      data_q   <= '0;
      dly_q    <= '0;
      tx_count <= '0;
      req_err  <= 1'b0;
    end else begin
      req_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_start) begin
            if (too_big) begin
              req_err <= 1'b1;
            end else begin
              cmd_q    <= req_cmd;
              addr_q   <= req_addr;
              len_q    <= req_len;
              wr_q     <= req_write;
              data_q   <= req_data;
              dly_q    <= req_delay;
              tx_count <= CNT_W'(frame_len(32'(req_len), req_write));
              k        <= '0;
              state    <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          k <= k + CNT_W'(1);
          if (load_last) state <= ST_ACK;
        end
        ST_ACK:  state <= ST_WAIT;
        ST_WAIT: if (!tx_done) state <= ST_GO;
        ST_GO:   state <= ST_SEND;
        ST_SEND: if (last_acc) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Byte for frame position k.
  always_comb begin
    if (k < CNT_W'(3))
      wr_data = hdr_byte(cmd_q, addr_q, k[1:0]);
    else if (k == CNT_W'(3) && len_q != '0)
      wr_data = 8'(len_q - LEN_W'(1));
    else
      wr_data = pay_b[pidx];
  end

  assign wr_en    = (state == ST_LOAD);
  assign wr_first = wr_en && (k == '0);
  assign done_ack = (state == ST_ACK);
  assign go       = (state == ST_GO);

  // The direction flag only matters through the count computed at accept.
  logic unused_wr;
  assign unused_wr = wr_q;

endmodule

// File: rtl/aux_frm_tx.sv
module aux_frm_tx #(
  parameter int CNT_W = 5,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DLY_W-1:0] delay,
  input  logic [CNT_W-1:0] count,
  input  logic             byte_ready,
  output logic             byte_valid,
  output logic [CNT_W-1:0] rd_idx,
  output logic             last_acc,
  output logic             active
);

  logic [DLY_W-1:0] dly;
  logic             at_last;

  assign at_last    = (rd_idx == count - CNT_W'(1));
  assign byte_valid = active && (dly == '0);
  assign last_acc   = byte_valid && byte_ready && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      dly    <= '0;
      rd_idx <= '0;
    end else if (go) begin
      active <= 1'b1;
      dly    <= delay;
      rd_idx <= '0;
    end else if (active) begin
      if (dly != '0) begin
        dly <= dly - DLY_W'(1);
      end else if (byte_ready) begin
        if (at_last) active <= 1'b0;
        else         rd_idx <= rd_idx + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer #(
  parameter int MAX_LEN = 16,
  parameter int DLY_W   = 4,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = $clog2(MAX_LEN + 5)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_start,
  input  logic [3:0]           req_cmd,
  input  logic [19:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 req_write,
  input  logic [8*MAX_LEN-1:0] req_data,
  input  logic [DLY_W-1:0]     req_delay,
  output logic                 req_err,
  output logic                 done_ack,
  input  logic                 tx_done,
  output logic                 go,
  output logic [CNT_W-1:0]     tx_count,
  output logic                 busy,
  output logic                 byte_valid,
  input  logic                 byte_ready,
  output logic [7:0]           byte_data
);

  localparam int DEPTH = MAX_LEN + 4;

  logic             load_we;
  logic             load_first;
  logic [7:0]       load_data;
  logic [DLY_W-1:0] dly_q;
  logic [CNT_W-1:0] rd_idx;
  logic             last_acc;
  logic             tx_active;

  aux_frm_seq #(
    .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W), .DLY_W(DLY_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .req_cmd   (req_cmd),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_write (req_write),
    .req_data  (req_data),
    .req_delay (req_delay),
    .tx_done   (tx_done),
    .last_acc  (last_acc),
    .req_err   (req_err),
    .done_ack  (done_ack),
    .go        (go),
    .tx_count  (tx_count),
    .dly_q     (dly_q),
    .wr_en     (load_we),
    .wr_first  (load_first),
    .wr_data   (load_data)
  );

  aux_frm_buf #(.DEPTH(DEPTH), .IDX_W(CNT_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (load_we),
    .wr_first (load_first),
    .wr_data  (load_data),
    .rd_idx   (rd_idx),
    .rd_data  (byte_data)
  );

  aux_frm_tx #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .delay      (dly_q),
    .count      (tx_count),
    .byte_ready (byte_ready),
    .byte_valid (byte_valid),
    .rd_idx     (rd_idx),
    .last_acc   (last_acc),
    .active     (tx_active)
  );

  assign busy = go | tx_active;

endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       tx_done,
  input logic       done_ack,
  input logic       req_err,
  input logic       busy,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_data,
  input logic       last_acc,
  input logic       load_we
);

  // R6
  go_needs_done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !tx_done);

  // R6
  ack_not_with_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ack |=> !go);

  // R6
  ack_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_we) |-> done_ack);

  // R6
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go, done_ack, req_err}));

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  // R9
  busy_covers_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> busy);

  // R9
  busy_ends_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_acc));

  // R10
  err_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!busy && !load_we));

endmodule

bind aux_req_framer aux_req_framer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .go         (go),
  .tx_done    (tx_done),
  .done_ack   (done_ack),
  .req_err    (req_err),
  .busy       (busy),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .byte_data  (byte_data),
  .last_acc   (last_acc),
  .load_we    (load_we)
);

// File: tb/test_aux_req_framer.sv
`timescale 1ns/1ps
module test_aux_req_framer;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_start = 1'b0;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic         req_write = 1'b0;
  logic [127:0] req_data = '0;
  logic [3:0]   req_delay = '0;
  logic         req_err;
  logic         done_ack;
  logic         tx_done = 1'b1;
  logic         go;
  logic [4:0]   tx_count;
  logic         busy;
  logic         byte_valid;
  logic         byte_ready = 1'b0;
  logic [7:0]   byte_data;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  aux_req_framer i_aux_req_framer (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .req_data(req_data), .req_delay(req_delay), .req_err(req_err),
    .done_ack(done_ack), .tx_done(tx_done), .go(go), .tx_count(tx_count),
    .busy(busy), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data)
  );

  // {cmd, addr, len, write, delay, ready mode}
  localparam bit [35:0] VECS [8] = '{
    {4'h8, 20'h12345, 5'd0,  1'b1, 4'd0,  2'd0},
    {4'h9, 20'hABCDE, 5'd0,  1'b0, 4'd2,  2'd1},
    {4'h9, 20'h00F0F, 5'd4,  1'b0, 4'd0,  2'd0},
    {4'h8, 20'h70001, 5'd4,  1'b1, 4'd1,  2'd1},
    {4'h4, 20'hFFFFF, 5'd1,  1'b1, 4'd3,  2'd2},
    {4'h5, 20'h00050, 5'd16, 1'b0, 4'd0,  2'd2},
    {4'h8, 20'h5A5A5, 5'd16, 1'b1, 4'd0,  2'd1},
    {4'h1, 20'h00000, 5'd2,  1'b1, 4'd15, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int i, input logic [19:0] a);
    return 8'(a[7:0] + 8'(i * 29) + 8'h3c);
  endfunction

  task automatic run_req(input logic [3:0] c, input logic [19:0] a,
                         input logic [4:0] l, input bit w, input logic [3:0] d,
                         input logic [1:0] rm, input int hold, input bit poke);
    logic [7:0] exp [20];
    int n, t, idx, k;
    bit stalled, rdy;
    logic [7:0] held;
    string tag;
    exp[0] = {c, a[19:16]};
    exp[1] = a[15:8];
    exp[2] = a[7:0];
    n = 3;
    if (l != 0) begin exp[3] = 8'(l - 1); n = 4; end
    if (w) for (int i = 0; i < int'(l); i++) exp[4 + i] = pay(i, a);
    if (w) n = n + int'(l);
    held = '0;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_len = l; req_write = w; req_delay = d;
    for (int i = 0; i < 16; i++) req_data[8*i +: 8] = pay(i, a);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    t = 0;
    while (!done_ack && t < 100) begin @(negedge clk); t++; end
    chk(done_ack, "R6 done_ack after load", done_ack, 1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(!go, "R6 go withheld while tx_done high", go, 0);
    end
    tx_done = 1'b0;
    t = 0;
    while (!go && t < 20) begin @(negedge clk); t++; end
    chk(go, "R6 go after tx_done low", go, 1);
    chk(tx_count == 5'(n), "R4 tx_count", tx_count, n);
    chk(busy, "R9 busy at go", busy, 1);
    t = 0;
    do begin @(negedge clk); t++; end while (!byte_valid && t < 40);
    chk(t == int'(d) + 1, "R7 start delay", t, int'(d) + 1);
    idx = 0; k = 0; stalled = 0;
    while (idx < n && k < 300) begin
      if (idx == 0) tag = "R1 byte0";
      else if (idx < 3) tag = "R2 address byte";
      else if (idx == 3 && l != 0) tag = "R3 length byte";
      else tag = "R5 payload byte";
      chk(byte_valid, "R8 valid held in stream", byte_valid, 1);
      chk(busy, "R9 busy in stream", busy, 1);
      chk(byte_data == exp[idx], tag, byte_data, exp[idx]);
      if (stalled) chk(byte_data == held, "R8 data held on stall", byte_data, held);
      case (rm)
        2'd0:    rdy = 1'b1;
        2'd1:    rdy = k[0];
        default: rdy = (k >= 2);
      endcase
      if (poke && k == 0) begin
        req_cmd = 4'hF; req_addr = 20'h0; req_len = 5'd3; req_write = 1'b1;
        req_start = 1'b1;
      end
      byte_ready = rdy;
      if (rdy) begin idx++; stalled = 0; end
      else begin stalled = 1; held = byte_data; end
      k++;
      @(negedge clk);
      req_start = 1'b0;
    end
    byte_ready = 1'b0;
    chk(idx == n, "R4 bytes sent", idx, n);
    chk(!busy, "R9 busy low after last", busy, 0);
    chk(!byte_valid, "R8 no byte after last", byte_valid, 0);
    tx_done = 1'b1;
    if (poke) begin
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        chk(!done_ack && !go && !req_err, "R11 mid-stream start ignored",
            {done_ack, go, req_err}, 0);
      end
    end
  endtask

  task automatic try_oversize(input logic [4:0] l);
    @(negedge clk);
    req_len = l; req_write = 1'b1; req_cmd = 4'h8; req_addr = 20'h11111;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(req_err, "R10 err pulse", req_err, 1);
    @(negedge clk);
    chk(!req_err, "R10 err one cycle", req_err, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!done_ack && !go && !busy, "R10 no frame on oversize",
          {done_ack, go, busy}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({busy, go, done_ack, req_err, byte_valid} == 5'b0, "R12 outputs in reset",
        {busy, go, done_ack, req_err, byte_valid}, 0);
    chk(tx_count == 5'd0, "R12 tx_count in reset", tx_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, go, done_ack, req_err, byte_valid} == 5'b0, "R12 outputs after reset",
        {busy, go, done_ack, req_err, byte_valid}, 0);
    for (int v = 0; v < 8; v++) begin
      run_req(VECS[v][35:32], VECS[v][31:12], VECS[v][11:7], VECS[v][6],
              VECS[v][5:2], VECS[v][1:0], v % 3, 1'b0);
    end
    try_oversize(5'd17);
    try_oversize(5'd31);
    // R11 start injected mid-stream, then a normal request still works
    run_req(4'h9, 20'h3C3C3, 5'd2, 1'b1, 4'd1, 2'd2, 1, 1'b1);
    run_req(4'h0, 20'h80000, 5'd1, 1'b0, 4'd0, 2'd0, 0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule